// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN identifier is to be accepted. The identifier arrives as a group of bytes together with a one-cycle valid strobe. Each byte is compared with a programmable acceptance-code byte. A matching mask byte picks, bit by bit, which positions take part in the comparison. The decision is registered. It comes out as a held accept level and as a one-cycle hit pulse.

The code and mask registers sit behind a small register bus and can be read at any time. Writes take effect only while the controller is in initialization mode, which means the initialization request and the initialization acknowledge are both high. A write at any other time is dropped without any error indication. Out of reset every mask bit is 1, so every identifier is accepted.

Top module: `can_id_filter`

## Requirements
- R1: After reset every code register reads 0x00, every mask register reads 0xFF, and `accept` and `hit` are 0.
- R2: `reg_rdata` shows the register selected by `reg_addr` in the same cycle, in every mode. Addresses 0..3 select code byte k, which is compared with `id_data[8k+7:8k]`. Addresses 4..7 select mask byte k-4.
- R3: A write with `reg_wr` high is stored at the next clock edge only when `init_req` and `init_ack` are both 1. With any other combination of the two flags, every register keeps its value.
- R4: For each bit whose mask bit is 0, the identifier bit must equal the code bit, or the identifier is rejected.
- R5: For each bit whose mask bit is 1, the identifier bit has no effect on the decision.
- R6: An identifier is accepted only when every bit that has a mask bit of 0 matches, across all four bytes.
- R7: `accept` takes the decision for the identifier presented with `id_valid` at the next clock edge. When `id_valid` is low, `accept` holds its value.
- R8: `hit` is 1 for exactly the one cycle after an accepted valid identifier, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_req | input | 1 | Initialization mode requested |
| init_ack | input | 1 | Initialization mode acknowledged |
| reg_addr | input | 3 | Register select (0..3 code, 4..7 mask) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| id_valid | input | 1 | Identifier valid strobe |
| id_data | input | 32 | Received identifier bytes, byte k at bits 8k+7:8k |
| accept | output | 1 | Registered acceptance decision, held |
| hit | output | 1 | One-cycle pulse for an accepted identifier |

## Verification
The assertions assume that `init_req`, `init_ack`, `reg_wr` and `id_valid` are synchronous and free of X after reset. They also assume that the configuration can be changed in the same cycle as an identifier is presented, so the expected decision is always taken from the register values before the edge. The stimulus drives every input on the falling edge and never writes and presents an identifier in the same cycle. Each decision therefore depends only on the registers as they were programmed earlier.

// File: rtl/can_id_filter_pkg.sv
package can_id_filter_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Bits that take part (mask 0) must agree with the code.
  function automatic logic byte_passes(byte_t id_b, byte_t code_b, byte_t mask_b);
    byte_t diff;
    diff = (id_b ^ code_b) & ~mask_b;
    return (diff == '0);
  endfunction

  function automatic logic wr_permitted(logic req, logic ack);
    return req & ack;
  endfunction
endpackage

// File: rtl/can_id_filter_regs.sv
module can_id_filter_regs
  import can_id_filter_pkg::*;
#(
  parameter int NUM_BYTES = 4,
  parameter int ADDR_W    = $clog2(2*NUM_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_ok,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [BYTE_W-1:0]           reg_wdata,
  output logic [BYTE_W-1:0]           reg_rdata,
  output logic [NUM_BYTES*BYTE_W-1:0] code_bits,
  output logic [NUM_BYTES*BYTE_W-1:0] mask_bits
);
  localparam int NUM_REGS = 2*NUM_BYTES;

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_reg
    logic code_sel, mask_sel;
    assign code_sel = reg_wr && wr_ok && (reg_addr == ADDR_W'(k));
    assign mask_sel = reg_wr && wr_ok && (reg_addr == ADDR_W'(k + NUM_BYTES));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_bits[k*BYTE_W +: BYTE_W] <= '0;
        mask_bits[k*BYTE_W +: BYTE_W] <= '1;
      end else begin
        if (code_sel) code_bits[k*BYTE_W +: BYTE_W] <= reg_wdata;
        if (mask_sel) mask_bits[k*BYTE_W +: BYTE_W] <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (reg_addr == ADDR_W'(r)) begin
        if (r < NUM_BYTES) reg_rdata = code_bits[r*BYTE_W +: BYTE_W];
        else               reg_rdata = mask_bits[(r-NUM_BYTES)*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/can_id_filter_match.sv
module can_id_filter_match
  import can_id_filter_pkg::*;
#(
  parameter int NUM_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        id_valid,
  input  logic [NUM_BYTES*BYTE_W-1:0] id_data,
  input  logic [NUM_BYTES*BYTE_W-1:0] code_bits,
  input  logic [NUM_BYTES*BYTE_W-1:0] mask_bits,
  output logic [NUM_BYTES-1:0]        byte_ok,
  output logic                        accept,
  output logic                        hit
);
  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_cmp
    assign byte_ok[k] = byte_passes(id_data[k*BYTE_W +: BYTE_W],
                                    code_bits[k*BYTE_W +: BYTE_W],
                                    mask_bits[k*BYTE_W +: BYTE_W]);
  end

  logic all_ok;
  assign all_ok = &byte_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept <= 1'b0;
      hit    <= 1'b0;
    end else begin
      hit <= id_valid && all_ok;
      if (id_valid) accept <= all_ok;
    end
  end
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import can_id_filter_pkg::*;
#(
  parameter int NUM_BYTES = 4,
  parameter int ADDR_W    = $clog2(2*NUM_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        init_req,
  input  logic                        init_ack,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic                        reg_wr,
  input  logic [BYTE_W-1:0]           reg_wdata,
  output logic [BYTE_W-1:0]           reg_rdata,
  input  logic                        id_valid,
  input  logic [NUM_BYTES*BYTE_W-1:0] id_data,
  output logic                        accept,
  output logic                        hit
);
  logic                        wr_ok;
  logic [NUM_BYTES*BYTE_W-1:0] code_bits;
  logic [NUM_BYTES*BYTE_W-1:0] mask_bits;
  logic [NUM_BYTES-1:0]        byte_ok;

  assign wr_ok = wr_permitted(init_req, init_ack);

  can_id_filter_regs #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .code_bits(code_bits), .mask_bits(mask_bits)
  );

  can_id_filter_match #(.NUM_BYTES(NUM_BYTES)) u_match (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_data(id_data),
    .code_bits(code_bits), .mask_bits(mask_bits), .byte_ok(byte_ok),
    .accept(accept), .hit(hit)
  );
endmodule

// File: rtl/can_id_filter_chk.sv
module can_id_filter_chk
  import can_id_filter_pkg::*;
#(
  parameter int NUM_BYTES = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        init_req,
  input logic                        init_ack,
  input logic                        reg_wr,
  input logic                        id_valid,
  input logic [NUM_BYTES*BYTE_W-1:0] id_data,
  input logic [NUM_BYTES*BYTE_W-1:0] code_bits,
  input logic [NUM_BYTES*BYTE_W-1:0] mask_bits,
  input logic                        accept,
  input logic                        hit
);
  // R3: a write outside initialization mode leaves all registers unchanged
  a_r3_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !(init_req && init_ack)) |=> ($stable(code_bits) && $stable(mask_bits)));

  // R6: the decision follows the masked comparison of the previous cycle
  a_r6_decision: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> (accept == $past(((id_data ^ code_bits) & ~mask_bits) == '0)));

  // R5: an all-ones mask accepts whatever identifier arrives
  a_r5_all_dont_care: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && (&mask_bits)) |=> accept);

  // R7: accept holds while no identifier is presented
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> $stable(accept));

  // R8: hit only after a valid identifier, and only when accepted
  a_r8_hit_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($past(id_valid) && accept));

  a_r8_hit_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && (((id_data ^ code_bits) & ~mask_bits) == '0)) |=> hit);
endmodule

bind can_id_filter can_id_filter_chk #(.NUM_BYTES(NUM_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
  .reg_wr(reg_wr), .id_valid(id_valid), .id_data(id_data),
  .code_bits(code_bits), .mask_bits(mask_bits), .accept(accept), .hit(hit)
);

// File: tb/can_id_filter_test.sv
`timescale 1ns/1ps
module can_id_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_req = 1'b0, init_ack = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        id_valid = 1'b0;
  logic [31:0] id_data = '0;
  logic        accept, hit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_code = 32'h0;
  logic [31:0] m_mask = 32'hFFFF_FFFF;

  always #2 clk = ~clk;

  can_id_filter uut (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .id_valid(id_valid), .id_data(id_data),
    .accept(accept), .hit(hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (init_req && init_ack) begin
      if (a < 4) m_code[a*8 +: 8] = d;
      else       m_mask[(a-4)*8 +: 8] = d;
    end
  endtask

  function automatic logic [7:0] model_reg(input int a);
    return (a < 4) ? m_code[a*8 +: 8] : m_mask[(a-4)*8 +: 8];
  endfunction

  task automatic read_all(input string req);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      reg_addr = 3'(a);
      #1;
      check(req, {24'h0, reg_rdata}, {24'h0, model_reg(a)});
    end
  endtask

  function automatic logic expect_acc(input logic [31:0] id);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < 32; b++)
      if (!m_mask[b] && (id[b] != m_code[b])) ok = 1'b0;
    return ok;
  endfunction

  task automatic present(input logic [31:0] id, input string req);
    logic e;
    e = expect_acc(id);
    @(negedge clk);
    id_data = id; id_valid = 1'b1;
    @(negedge clk);
    id_valid = 1'b0;
    check(req, {31'h0, accept}, {31'h0, e});
    check("R8", {31'h0, hit}, {31'h0, e});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] lcg;
    logic        prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    check("R1", {31'h0, accept}, 32'h0);
    check("R1", {31'h0, hit}, 32'h0);
    read_all("R1");
    // R5: default all don't care accepts anything
    present(32'hDEAD_BEEF, "R5");

    // R3: writes rejected for every non-init flag combination
    for (int f = 0; f < 3; f++) begin
      init_req = f[0]; init_ack = f[1];
      for (int a = 0; a < 8; a++) wr(3'(a), 8'(8'h11 * (a + 1)));
      read_all("R3");
    end

    // Enter init mode and program
    init_req = 1'b1; init_ack = 1'b1;
    for (int a = 0; a < 8; a++) wr(3'(a), 8'(8'h3C + 8'(a * 37)));
    read_all("R3");
    // R2: reads work after leaving init mode as well
    init_req = 1'b0; init_ack = 1'b0;
    read_all("R2");

    // R4/R5: one care bit at a time, both polarities of the identifier bit
    for (int b = 0; b < 32; b++) begin
      init_req = 1'b1; init_ack = 1'b1;
      for (int k = 0; k < 4; k++) begin
        wr(3'(4 + k), (b / 8 == k) ? ~(8'h1 << (b % 8)) : 8'hFF);
        wr(3'(k), 8'(8'hA5 ^ 8'(b)));
      end
      init_req = 1'b0;
      present(m_code ^ (32'h1 << b), "R4");
      present(m_code, "R4");
      present(m_code ^ ~(32'h1 << b), "R5");
    end

    // R6: near-exhaustive sweep of byte 0 with upper nibble caring
    init_req = 1'b1;
    wr(3'd0, 8'h5A); wr(3'd1, 8'h00); wr(3'd2, 8'hFF); wr(3'd3, 8'h81);
    wr(3'd4, 8'h0F); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    init_req = 1'b0;
    for (int v = 0; v < 256; v++) present({24'h123456, 8'(v)}, "R6");

    // R6: multi-byte masks, pseudo-random identifiers around the code
    init_req = 1'b1;
    wr(3'd4, 8'h00); wr(3'd5, 8'hF0); wr(3'd6, 8'h3C); wr(3'd7, 8'h00);
    init_req = 1'b0;
    lcg = 32'h1357_9BDF;
    for (int n = 0; n < 200; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      present((n % 2 == 0) ? (m_code ^ (lcg & m_mask)) : lcg, "R6");
    end

    // R7: accept holds with no valid, hit returns to 0
    present(m_code, "R7");
    prev = accept;
    present(~m_code, "R7");
    prev = accept;
    repeat (5) begin
      @(negedge clk);
      id_data = m_code;
      check("R7", {31'h0, accept}, {31'h0, prev});
      check("R8", {31'h0, hit}, 32'h0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule